// File: doc/BRIEF.md
# SDRAM Command Front-End with Clock-Enable Gating

This block is the input stage on the device side of a multi-bank SDRAM model. On every rising clock edge it samples the active-low chip-select, row-strobe, column-strobe and write-enable pins, the bank-select bits, the address bus and the clock-enable pin. It turns each valid pin pattern into a one-cycle command strobe that carries the bank and the address field that goes with that command. It also keeps an open or closed flag for every bank.

Clock-enable gating works as follows. Sampling the enable low freezes the block from the next edge onward. If every bank is closed after that edge, the frozen state is reported as power-down. Otherwise it is reported as clock suspend. While the block is frozen, all command inputs are ignored and the strobe outputs hold their values. The first edge that samples the enable high both ends the frozen state and accepts the command presented on that edge. A mode-register write is refused while any bank is open. Reads and writes to a closed bank are refused and flagged.

Top module: `sdram_cmd_frontend`

## Requirements
- R1: While reset is asserted and after it is released with no command yet accepted, every output is zero.
- R2: On an accepted edge with chip-select low, the pin pattern {row, column, write} maps to a command as follows: 011 is activate (code 1), 101 is read (code 2), 100 is write (code 3), 010 is precharge (code 4), 001 is auto-refresh (code 5) and 000 is mode write (code 6). After that edge, `cmd_vld` is high for exactly one cycle with `cmd_code` set to the command's code.
- R3: Chip-select high (whatever the other pins are) and the pattern 111 with chip-select low give no strobe and change no bank flag, command field or mode word.
- R4: Activate captures the bank and the full 12-bit row into `cmd_bank` and `cmd_addr` and sets that bank's bit in `bank_open`. Precharge captures the bank, reports address 0 and clears that bank's bit.
- R5: Read and write to an open bank report the low 8 address bits as the column, zero-extended, in `cmd_addr`. Auto-refresh reports bank 0 and address 0.
- R6: A read or write to a closed bank gives no strobe and pulses `illegal` for one cycle. The command fields stay unchanged.
- R7: A mode write is accepted only when all banks are closed. `mode_word` takes the address one edge later, and only if the bank bits are 0. With any bank open, the mode write pulses `illegal` and changes nothing.
- R8: When clock-enable is sampled low and a bank is left open after that edge, `suspend` is set from the next cycle. While the block stays frozen, commands are ignored: no strobe, no change of bank flags or command fields.
- R9: When clock-enable is sampled low and all banks are closed after that edge, `pdown` is set instead of `suspend`. Inputs are ignored in the same way.
- R10: The edge that samples clock-enable high while the block is frozen clears `suspend` or `pdown` and accepts the command presented on that edge.
- R11: The command presented on the edge where clock-enable is first sampled low is still carried out. Gating starts only with the following edge.
- R12: `suspend` and `pdown` are never high together, and `cmd_vld` and `illegal` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock-enable pin |
| cs_n | input | 1 | Chip-select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank-select bits |
| addr | input | 12 | Multiplexed address bus |
| cmd_vld | output | 1 | One-cycle strobe for an accepted command |
| cmd_code | output | 3 | Code of the last accepted command |
| cmd_bank | output | 2 | Bank of the last accepted command |
| cmd_addr | output | 12 | Row, column, mode data or zero |
| illegal | output | 1 | One-cycle pulse for a refused command |
| suspend | output | 1 | Clock suspend in effect |
| pdown | output | 1 | Power-down in effect |
| bank_open | output | 4 | One bit per open bank |
| mode_word | output | 12 | Last accepted mode-register data |

## Verification
The assertions check the following on every cycle: the two frozen states and the strobe/refusal pulses never coincide; power-down only appears with all banks closed; a frozen cycle with the enable still low produces no strobe and no change to the bank flags; an activate or precharge strobe agrees with the bank flag it names; and an accepted mode write always follows a cycle with every bank closed. The bench scenarios are needed for the rest: the exact fields captured for each command, the edge on which freezing starts and ends, the command accepted on the exit edge, and the rule that a mode write with nonzero bank bits leaves the mode word alone.

// File: rtl/sdcf_pkg.sv
package sdcf_pkg;

   typedef enum logic [2:0] {
      CMD_NONE = 3'd0,
      CMD_ACT  = 3'd1,
      CMD_RD   = 3'd2,
      CMD_WR   = 3'd3,
      CMD_PRE  = 3'd4,
      CMD_REF  = 3'd5,
      CMD_MRS  = 3'd6
   } sdcf_cmd_e;

   function automatic logic is_access(input sdcf_cmd_e c);
      return (c == CMD_RD) || (c == CMD_WR);
   endfunction

endpackage

// File: rtl/sdcf_decode.sv
module sdcf_decode
   import sdcf_pkg::*;
(
   input  logic      cs_n,
   input  logic      ras_n,
   input  logic      cas_n,
   input  logic      we_n,
   output sdcf_cmd_e cmd
);

   always_comb begin
      cmd = CMD_NONE;
      if (!cs_n) begin
         unique case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = CMD_MRS;
            default: cmd = CMD_NONE;
         endcase
      end
   end

endmodule

// File: rtl/sdcf_bank_track.sv
module sdcf_bank_track
   import sdcf_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step,
   input  sdcf_cmd_e            cmd,
   input  logic [BANK_W-1:0]    bank,
   output logic [NUM_BANKS-1:0] open_q,
   output logic [NUM_BANKS-1:0] open_nx,
   output logic                 hit_open,
   output logic                 all_idle
);

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      always_comb begin
         open_nx[i] = open_q[i];
         if (step && (bank == BANK_W'(i))) begin
            if (cmd == CMD_ACT)
               open_nx[i] = 1'b1;
            else if (cmd == CMD_PRE)
               open_nx[i] = 1'b0;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            open_q[i] <= 1'b0;
         else
            open_q[i] <= open_nx[i];
      end
   end

   assign hit_open = open_q[bank];
   assign all_idle = ~|open_q;

endmodule

// File: rtl/sdcf_cke_gate.sv
module sdcf_cke_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  logic idle_after,
   output logic accept,
   output logic susp_q,
   output logic pd_q
);

   logic frozen;

   assign frozen = susp_q | pd_q;
   assign accept = !frozen || cke;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         susp_q <= 1'b0;
         pd_q   <= 1'b0;
      end else if (accept) begin
         susp_q <= !cke && !idle_after;
         pd_q   <= !cke && idle_after;
      end
   end

endmodule

// File: rtl/sdram_cmd_frontend.sv
module sdram_cmd_frontend
   import sdcf_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int ADDR_W    = 12,
   parameter int COL_W     = 8,
   localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BANK_W-1:0]    ba,
   input  logic [ADDR_W-1:0]    addr,
   output logic                 cmd_vld,
   output logic [2:0]           cmd_code,
   output logic [BANK_W-1:0]    cmd_bank,
   output logic [ADDR_W-1:0]    cmd_addr,
   output logic                 illegal,
   output logic                 suspend,
   output logic                 pdown,
   output logic [NUM_BANKS-1:0] bank_open,
   output logic [ADDR_W-1:0]    mode_word
);

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_chk_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (COL_W < 1 || COL_W > ADDR_W) begin : g_chk_col
      $error("COL_W must lie between 1 and ADDR_W");
   end

   sdcf_cmd_e              raw_cmd;
   sdcf_cmd_e              eff_cmd;
   sdcf_cmd_e              cmd_q;
   logic                   accept;
   logic                   refused;
   logic                   go;
   logic                   hit_open;
   logic                   all_idle;
   logic [NUM_BANKS-1:0]   open_nx;
   logic [ADDR_W-1:0]      col_ext;
   logic [ADDR_W-1:0]      addr_sel;
   logic [BANK_W-1:0]      bank_sel;
   logic                   vld_q;
   logic                   ill_q;
   logic [BANK_W-1:0]      bank_q;
   logic [ADDR_W-1:0]      addr_q;
   logic [ADDR_W-1:0]      mode_q;

   sdcf_decode u_dec (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cmd   (raw_cmd)
   );

   always_comb begin
      refused = 1'b0;
      if (is_access(raw_cmd) && !hit_open)
         refused = 1'b1;
      if ((raw_cmd == CMD_MRS) && !all_idle)
         refused = 1'b1;
      eff_cmd = refused ? CMD_NONE : raw_cmd;
   end

   assign go = accept && (eff_cmd != CMD_NONE);

   sdcf_bank_track #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W)
   ) u_banks (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (accept),
      .cmd      (eff_cmd),
      .bank     (ba),
      .open_q   (bank_open),
      .open_nx  (open_nx),
      .hit_open (hit_open),
      .all_idle (all_idle)
   );

   sdcf_cke_gate u_gate (
      .clk        (clk),
      .rst_n      (rst_n),
      .cke        (cke),
      .idle_after (~|open_nx),
      .accept     (accept),
      .susp_q     (suspend),
      .pd_q       (pdown)
   );

   if (COL_W == ADDR_W) begin : g_col_full
      assign col_ext = addr;
   end else begin : g_col_pad
      assign col_ext = {{(ADDR_W-COL_W){1'b0}}, addr[COL_W-1:0]};
   end

   always_comb begin
      addr_sel = '0;
      bank_sel = ba;
      unique case (eff_cmd)
         CMD_ACT, CMD_MRS: addr_sel = addr;
         CMD_RD, CMD_WR:   addr_sel = col_ext;
         CMD_REF:          bank_sel = '0;
         default:          addr_sel = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         ill_q  <= 1'b0;
         cmd_q  <= CMD_NONE;
         bank_q <= '0;
         addr_q <= '0;
         mode_q <= '0;
      end else begin
         vld_q <= go;
         ill_q <= accept && refused;
         if (go) begin
            cmd_q  <= eff_cmd;
            bank_q <= bank_sel;
            addr_q <= addr_sel;
            if ((eff_cmd == CMD_MRS) && (ba == '0))
               mode_q <= addr;
         end
      end
   end

   assign cmd_vld   = vld_q;
   assign illegal   = ill_q;
   assign cmd_code  = cmd_q;
   assign cmd_bank  = bank_q;
   assign cmd_addr  = addr_q;
   assign mode_word = mode_q;

endmodule

// File: rtl/sdcf_checker.sv
module sdcf_checker #(
   parameter int NUM_BANKS = 4,
   parameter int BANK_W    = 2
)(
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cke,
   input logic                 cmd_vld,
   input logic [2:0]           cmd_code,
   input logic [BANK_W-1:0]    cmd_bank,
   input logic                 illegal,
   input logic                 suspend,
   input logic                 pdown,
   input logic [NUM_BANKS-1:0] bank_open
);

   AST_FROZEN_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(suspend && pdown)); // R12

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_vld && illegal)); // R12

   AST_PDOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      pdown |-> (bank_open == '0)); // R9

   AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ((suspend || pdown) && !cke) |=> (!cmd_vld && $stable(bank_open))); // R8

   AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_code == 3'd1) |-> bank_open[cmd_bank]); // R4

   AST_PRE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_code == 3'd4) |-> !bank_open[cmd_bank]); // R4

   AST_MRS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_code == 3'd6) |-> ($past(bank_open) == '0)); // R7

endmodule

bind sdram_cmd_frontend sdcf_checker #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W)
) u_sdcf_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cmd_vld   (cmd_vld),
   .cmd_code  (cmd_code),
   .cmd_bank  (cmd_bank),
   .illegal   (illegal),
   .suspend   (suspend),
   .pdown     (pdown),
   .bank_open (bank_open)
);

// File: tb/tb_sdram_cmd_frontend.sv
module tb_sdram_cmd_frontend;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke = 1'b1;
   logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0]  ba = '0;
   logic [11:0] addr = '0;
   logic        cmd_vld, illegal, suspend, pdown;
   logic [2:0]  cmd_code;
   logic [1:0]  cmd_bank;
   logic [11:0] cmd_addr, mode_word;
   logic [3:0]  bank_open;

   always #(CLK_P/2) clk = ~clk;

   sdram_cmd_frontend dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
      .cmd_vld(cmd_vld), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
      .cmd_addr(cmd_addr), .illegal(illegal), .suspend(suspend),
      .pdown(pdown), .bank_open(bank_open), .mode_word(mode_word)
   );

   typedef struct {
      bit        vld;
      bit [2:0]  cmd;
      bit [1:0]  bank;
      bit [11:0] addr;
      bit        ill;
      bit        su;
      bit        pd;
      bit [3:0]  open;
      bit [11:0] mode;
      string     tag;
   } exp_t;

   exp_t q[$];
   exp_t m_out;
   bit   m_frz;
   int   n_chk = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;

   function automatic bit [2:0] ref_dec(bit r, bit c, bit w);
      case ({r, c, w})
         3'b011:  return 3'd1;
         3'b101:  return 3'd2;
         3'b100:  return 3'd3;
         3'b010:  return 3'd4;
         3'b001:  return 3'd5;
         3'b000:  return 3'd6;
         default: return 3'd0;
      endcase
   endfunction

   task automatic step(bit k, bit s, bit r, bit c, bit w,
                       bit [1:0] b, bit [11:0] a, string tag);
      exp_t     e;
      bit [2:0] code;
      bit       bad;
      @(negedge clk);
      cke = k; cs_n = s; ras_n = r; cas_n = c; we_n = w; ba = b; addr = a;
      e = m_out;
      e.vld = 0;
      e.ill = 0;
      e.tag = tag;
      if (!m_frz || k) begin
         code = s ? 3'd0 : ref_dec(r, c, w);
         bad = 0;
         if ((code == 3'd2 || code == 3'd3) && !e.open[b]) begin bad = 1; code = 0; end
         if (code == 3'd6 && e.open != 0) begin bad = 1; code = 0; end
         if (code != 0) begin
            e.vld  = 1;
            e.cmd  = code;
            e.bank = (code == 3'd5) ? 2'd0 : b;
            e.addr = (code == 3'd1 || code == 3'd6) ? a :
                     (code == 3'd2 || code == 3'd3) ? {4'h0, a[7:0]} : 12'h0;
            if (code == 3'd1) e.open[b] = 1;
            if (code == 3'd4) e.open[b] = 0;
            if (code == 3'd6 && b == 0) e.mode = a;
         end
         e.ill = bad;
         m_frz = !k;
         e.su  = !k && (e.open != 0);
         e.pd  = !k && (e.open == 0);
      end
      m_out = e;
      q.push_back(e);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   // monitor: pops one expected item per edge after the driver queued it
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #(CLK_P/4);
         if (q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            if ({cmd_vld, cmd_code, cmd_bank, cmd_addr, illegal, suspend, pdown,
                 bank_open, mode_word} !==
                {e.vld, e.cmd, e.bank, e.addr, e.ill, e.su, e.pd, e.open, e.mode}) begin
               n_bad++;
               $display("FAIL %s: actual vld=%b cmd=%0d bank=%0d addr=%h ill=%b su=%b pd=%b open=%b mode=%h expected vld=%b cmd=%0d bank=%0d addr=%h ill=%b su=%b pd=%b open=%b mode=%h",
                        e.tag, cmd_vld, cmd_code, cmd_bank, cmd_addr, illegal, suspend,
                        pdown, bank_open, mode_word, e.vld, e.cmd, e.bank, e.addr,
                        e.ill, e.su, e.pd, e.open, e.mode);
            end
         end
      end
   end

   initial begin
      #(CLK_P * 5000);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      m_out = '{default: 0, tag: ""};
      m_frz = 0;
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      n_chk++;
      if ({cmd_vld, cmd_code, cmd_bank, cmd_addr, illegal, suspend, pdown, bank_open, mode_word} !== '0) begin
         n_bad++;
         $display("FAIL R1 reset: actual nonzero outputs expected all zero");
      end
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #(CLK_P/4);
      n_chk++;
      if ({cmd_vld, cmd_code, illegal, suspend, pdown, bank_open} !== '0) begin
         n_bad++;
         $display("FAIL R1 after release: actual nonzero expected all zero");
      end

      step(1, 0, 1, 1, 1, 2'd2, 12'hFFF, "R3 nop");
      step(1, 1, 0, 0, 0, 2'd1, 12'h123, "R3 deselect");
      step(1, 0, 1, 0, 1, 2'd1, 12'h044, "R6 read idle bank");
      step(1, 0, 0, 0, 0, 2'd0, 12'h032, "R7 mode write idle");
      step(1, 0, 0, 1, 1, 2'd1, 12'hABC, "R4 activate b1");
      step(1, 0, 0, 1, 1, 2'd3, 12'h123, "R4 activate b3");
      step(1, 0, 1, 0, 0, 2'd1, 12'hF5A, "R5 write column");
      step(1, 0, 1, 0, 1, 2'd3, 12'h0FF, "R5 read column");
      step(1, 0, 0, 0, 0, 2'd0, 12'h777, "R7 mode write refused");
      step(1, 0, 0, 0, 1, 2'd2, 12'h999, "R5 auto-refresh R2");
      step(0, 0, 1, 0, 1, 2'd1, 12'h011, "R11 read on entry edge");
      step(0, 0, 0, 1, 1, 2'd2, 12'h222, "R8 suspended ignore act");
      step(0, 0, 1, 1, 1, 2'd0, 12'h000, "R8 suspended nop");
      step(1, 0, 0, 1, 0, 2'd1, 12'h400, "R10 exit with precharge");
      step(1, 0, 0, 1, 0, 2'd3, 12'h000, "R4 precharge b3");
      step(0, 0, 1, 1, 1, 2'd0, 12'h000, "R9 enter power-down");
      step(0, 0, 0, 1, 1, 2'd0, 12'h555, "R9 pdown ignore act");
      step(0, 1, 1, 1, 1, 2'd0, 12'h000, "R9 pdown hold");
      step(1, 0, 0, 1, 1, 2'd0, 12'h007, "R10 exit with activate");
      step(1, 0, 1, 0, 0, 2'd2, 12'h0AA, "R6 write idle bank");
      step(1, 0, 0, 1, 0, 2'd0, 12'h000, "R4 precharge b0");
      step(1, 0, 0, 0, 0, 2'd2, 12'h3C3, "R7 mode write ext bank");
      step(0, 0, 0, 1, 1, 2'd3, 12'h0F0, "R11 act on entry edge R8");
      step(1, 0, 1, 0, 1, 2'd3, 12'h1E1, "R10 exit read");
      for (int i = 0; i < 8; i++) begin
         step(1, 0, 0, 1, (i % 2 == 1), 2'(i / 2), 12'(i * 291), "R2 act/pre sweep");
      end
      step(1, 0, 0, 1, 0, 2'd3, 12'h000, "R4 final precharge");
      step(1, 0, 1, 1, 1, 2'd0, 12'h000, "R3 idle nop");
      repeat (3) @(posedge clk);
      #(CLK_P/4);
      finish_run();
   end

endmodule